// File: doc/BRIEF.md
# Bonded Elasticity Slip Command Link

This block keeps the elasticity buffers of several bonded receive devices aligned. One device is the master. It watches the elasticity buffer of one of its four receive channels, chosen by a select input. At framing characters it decides whether the buffers should gain a character, lose one, or stay as they are. It sends that decision as a 2-bit command on a shared open-drain status bus, one command per parallel output cycle. When the master sees a word sync sequence on the selected channel, it sends a resynchronisation command instead.

Every other device is a slave. A slave reads the command from the bus and applies it to its own elasticity buffer. It can insert an extra K28.5 after the next framing character it reads out. It can drop the next framing character. It can re-centre its read pointer. Because every device acts at the same framing character, the bonded lanes stay in step.

A device drives the bus only when three things are true: it is the master, all four channels are bonded, and its receive parallel interface runs from the reference clock. At all other times it releases the bus, and the pull-up makes the bus read as the idle code. The buffer's write side and read side share one clock here, with a write strobe that marks each incoming entry.

Top module: `bond_slip_link`

## Requirements
- R1: When drive is qualified and the selected channel reports a word sync sequence, `bus_code_o` is 2'b00 in the cycle after those inputs are applied. This has priority over every other code.
- R2: When drive is qualified, there is no sync, and the selected channel shows a framing character, the next-cycle code is 2'b01 (add) if the fill is below DEPTH/4, 2'b10 (delete) if the fill is above 3*DEPTH/4, and 2'b11 otherwise. Without a framing character the code is 2'b11.
- R3: `mst_sel_i` picks channel k. The fill of channel k sits in bits [k*FW +: FW] of `ch_fill_i`, and its framing and sync flags sit in bit k of `ch_frame_i` and `ch_sync_i`. No other channel affects the code.
- R4: `bus_oe_o` is high exactly when `cfg_master_i`, `cfg_all_bonded_i` and `cfg_refclk_par_i` are all high. When the previous cycle's qualification was low, `bus_code_o` is the released level 2'b11.
- R5: A slave acts on `bus_code_i` only when `cfg_master_i` is low. On a master, and for code 2'b11, the bus has no effect on the buffer.
- R6: A framing character is an entry with its control flag set and a symbol of 10'h0FA or 10'h305. After an add command, the next framing character read out is delivered. The read after it then delivers an inserted entry with control set and symbol 10'h0FA, and consumes no buffer entry.
- R7: After a delete command, the next framing character reached by a read is consumed without being delivered (`rd_vld_o` stays low for that read), and the pending command is cleared.
- R8: Code 2'b00 moves the read pointer to the write pointer minus DEPTH/2. It clears any pending add, delete or insertion, and delivers nothing in that cycle.
- R9: An add or delete command that arrives while an earlier one is still pending replaces it.
- R10: Entries come out in write order, one cycle after the read. A read from an empty buffer gives `rd_vld_o` low, a write to a full buffer is dropped, and when `rd_en_i` is low the next cycle's `rd_vld_o` is low.
- R11: After reset `bus_code_o` is 2'b11, `rd_vld_o` is low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master_i | input | 1 | Device acts as bonding master |
| cfg_all_bonded_i | input | 1 | All four channels bonded |
| cfg_refclk_par_i | input | 1 | Receive parallel interface on reference clock |
| mst_sel_i | input | 2 | Channel that supplies buffer status |
| ch_fill_i | input | NCH*FW | Per-channel buffer fill levels |
| ch_frame_i | input | NCH | Per-channel framing character at output |
| ch_sync_i | input | NCH | Per-channel word sync sequence seen |
| bus_code_o | output | 2 | Command for the status bus |
| bus_oe_o | output | 1 | Bus drive enable (low = released) |
| bus_code_i | input | 2 | Command as read from the status bus |
| wr_en_i | input | 1 | Write an entry into the slave buffer |
| wr_ctl_i | input | 1 | Control flag of the written entry |
| wr_sym_i | input | 10 | Symbol of the written entry |
| rd_en_i | input | 1 | Read slot request |
| rd_vld_o | output | 1 | Read output carries an entry |
| rd_ctl_o | output | 1 | Control flag of the read entry |
| rd_sym_o | output | 10 | Symbol of the read entry |

## Verification
On every cycle, the assertions check the release level when drive is not qualified, the priority of the sync code, the idle code when no framing character is present, the empty slot after a resynchronisation, and that no entry is delivered without a read request. The bench's scenarios are needed to show slip behaviour that spans several cycles and depends on buffer contents. These are insertion after the right framing character, deletion of the right one, a newer command replacing a pending one, the pointer landing after a re-centre, and full or empty edges. For these the bench runs a reference model against write-biased and read-biased random traffic.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    localparam int SYM_W = 10;

    typedef enum logic [1:0] {
        BC_SYNC = 2'b00,
        BC_ADD  = 2'b01,
        BC_DEL  = 2'b10,
        BC_NORM = 2'b11
    } bcode_e;

    typedef enum logic [1:0] {
        PD_NONE = 2'd0,
        PD_ADD  = 2'd1,
        PD_DEL  = 2'd2
    } pend_e;

    typedef struct packed {
        logic             ctl;
        logic [SYM_W-1:0] sym;
    } ent_t;

    localparam logic [SYM_W-1:0] K_FRAME_N = 10'h0FA;
    localparam logic [SYM_W-1:0] K_FRAME_P = 10'h305;

    function automatic logic is_frame(ent_t e);
        return e.ctl && ((e.sym == K_FRAME_N) || (e.sym == K_FRAME_P));
    endfunction

    function automatic ent_t k_insert();
        ent_t e;
        e.ctl = 1'b1;
        e.sym = K_FRAME_N;
        return e;
    endfunction

    // Sync outranks slips; slips only at framing characters.
    function automatic bcode_e decide(logic sync, logic frame, logic below, logic above);
        if (sync)           return BC_SYNC;
        if (frame && below) return BC_ADD;
        if (frame && above) return BC_DEL;
        return BC_NORM;
    endfunction

endpackage

// File: rtl/bsl_chan_select.sv
module bsl_chan_select #(
    parameter int NCH  = 4,
    parameter int FW   = 5,
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [SELW-1:0]   sel_i,
    input  logic [NCH*FW-1:0] fill_i,
    input  logic [NCH-1:0]    frame_i,
    input  logic [NCH-1:0]    sync_i,
    output logic [FW-1:0]     fill_o,
    output logic              frame_o,
    output logic              sync_o
);
    logic [FW-1:0] fill_a [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_unpack
        assign fill_a[k] = fill_i[k*FW +: FW];
    end

    assign fill_o  = fill_a[sel_i];
    assign frame_o = frame_i[sel_i];
    assign sync_o  = sync_i[sel_i];
endmodule

// File: rtl/bsl_master_enc.sv
module bsl_master_enc
    import bsl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int FW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          qual_i,
    input  logic          sync_i,
    input  logic          frame_i,
    input  logic [FW-1:0] fill_i,
    output bcode_e        code_o
);
    localparam logic [FW-1:0] LO_TH = FW'(DEPTH / 4);
    localparam logic [FW-1:0] HI_TH = FW'((3 * DEPTH) / 4);

    bcode_e code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= BC_NORM;
        end else if (!qual_i) begin
            code_q <= BC_NORM;
        end else begin
            code_q <= decide(sync_i, frame_i, fill_i < LO_TH, fill_i > HI_TH);
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/bsl_slave_ebuf.sv
module bsl_slave_ebuf
    import bsl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic   clk,
    input  logic   rst,
    input  bcode_e cmd_i,
    input  logic   wr_en_i,
    input  ent_t   wr_ent_i,
    input  logic   rd_en_i,
    output logic   rd_vld_o,
    output ent_t   rd_ent_o
);
    localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);
    localparam logic [PW-1:0] FULL = PW'(DEPTH);

    ent_t          mem [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q, rd_ptr_d;
    logic [PW-1:0] fill;
    pend_e         pend_q, pend_d;
    logic          ins_q, ins_d;
    logic          vld_q, vld_d;
    ent_t          out_q, out_d;
    ent_t          head;
    logic          do_wr;

    assign fill  = wr_ptr_q - rd_ptr_q;
    assign do_wr = wr_en_i && (fill != FULL);
    assign head  = mem[rd_ptr_q[AW-1:0]];

    always_comb begin
        rd_ptr_d = rd_ptr_q;
        pend_d   = pend_q;
        ins_d    = ins_q;
        vld_d    = 1'b0;
        out_d    = out_q;
        if (cmd_i == BC_SYNC) begin
            rd_ptr_d = wr_ptr_q - HALF;
            pend_d   = PD_NONE;
            ins_d    = 1'b0;
        end else begin
            if (rd_en_i) begin
                if (ins_q) begin
                    out_d = k_insert();
                    vld_d = 1'b1;
                    ins_d = 1'b0;
                end else if (fill != '0) begin
                    rd_ptr_d = rd_ptr_q + PW'(1);
                    if (is_frame(head) && pend_q == PD_DEL) begin
                        pend_d = PD_NONE;
                    end else begin
                        vld_d = 1'b1;
                        out_d = head;
                        if (is_frame(head) && pend_q == PD_ADD) begin
                            ins_d  = 1'b1;
                            pend_d = PD_NONE;
                        end
                    end
                end
            end
            if (cmd_i == BC_ADD)      pend_d = PD_ADD;
            else if (cmd_i == BC_DEL) pend_d = PD_DEL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            pend_q   <= PD_NONE;
            ins_q    <= 1'b0;
            vld_q    <= 1'b0;
            out_q    <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            rd_ptr_q <= rd_ptr_d;
            pend_q   <= pend_d;
            ins_q    <= ins_d;
            vld_q    <= vld_d;
            out_q    <= out_d;
            if (do_wr) begin
                mem[wr_ptr_q[AW-1:0]] <= wr_ent_i;
                wr_ptr_q <= wr_ptr_q + PW'(1);
            end
        end
    end

    assign rd_vld_o = vld_q;
    assign rd_ent_o = out_q;
endmodule

// File: rtl/bond_slip_link.sv
module bond_slip_link
    import bsl_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DEPTH = 16,
    localparam int FW   = $clog2(DEPTH) + 1,
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master_i,
    input  logic              cfg_all_bonded_i,
    input  logic              cfg_refclk_par_i,
    input  logic [SELW-1:0]   mst_sel_i,
    input  logic [NCH*FW-1:0] ch_fill_i,
    input  logic [NCH-1:0]    ch_frame_i,
    input  logic [NCH-1:0]    ch_sync_i,
    output logic [1:0]        bus_code_o,
    output logic              bus_oe_o,
    input  logic [1:0]        bus_code_i,
    input  logic              wr_en_i,
    input  logic              wr_ctl_i,
    input  logic [SYM_W-1:0]  wr_sym_i,
    input  logic              rd_en_i,
    output logic              rd_vld_o,
    output logic              rd_ctl_o,
    output logic [SYM_W-1:0]  rd_sym_o
);
    logic          qual;
    logic [FW-1:0] sel_fill;
    logic          sel_frame, sel_sync;
    bcode_e        mst_code, slv_cmd;
    ent_t          wr_ent, rd_ent;

    assign qual = cfg_master_i && cfg_all_bonded_i && cfg_refclk_par_i;

    bsl_chan_select #(.NCH(NCH), .FW(FW)) u_sel (
        .sel_i  (mst_sel_i),
        .fill_i (ch_fill_i),
        .frame_i(ch_frame_i),
        .sync_i (ch_sync_i),
        .fill_o (sel_fill),
        .frame_o(sel_frame),
        .sync_o (sel_sync)
    );

    bsl_master_enc #(.DEPTH(DEPTH)) u_enc (
        .clk    (clk),
        .rst    (rst),
        .qual_i (qual),
        .sync_i (sel_sync),
        .frame_i(sel_frame),
        .fill_i (sel_fill),
        .code_o (mst_code)
    );

    assign bus_code_o = mst_code;
    assign bus_oe_o   = qual;

    // A master never obeys the bus it drives.
    assign slv_cmd    = cfg_master_i ? BC_NORM : bcode_e'(bus_code_i);
    assign wr_ent.ctl = wr_ctl_i;
    assign wr_ent.sym = wr_sym_i;

    bsl_slave_ebuf #(.DEPTH(DEPTH)) u_ebuf (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (slv_cmd),
        .wr_en_i (wr_en_i),
        .wr_ent_i(wr_ent),
        .rd_en_i (rd_en_i),
        .rd_vld_o(rd_vld_o),
        .rd_ent_o(rd_ent)
    );

    assign rd_ctl_o = rd_ent.ctl;
    assign rd_sym_o = rd_ent.sym;
endmodule

// File: rtl/bond_slip_link_chk.sv
module bond_slip_link_chk #(
    parameter int NCH  = 4,
    parameter int SELW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_master_i,
    input logic            cfg_all_bonded_i,
    input logic            cfg_refclk_par_i,
    input logic [SELW-1:0] mst_sel_i,
    input logic [NCH-1:0]  ch_frame_i,
    input logic [NCH-1:0]  ch_sync_i,
    input logic [1:0]      bus_code_o,
    input logic [1:0]      bus_code_i,
    input logic            rd_en_i,
    input logic            rd_vld_o
);
    logic q;
    assign q = cfg_master_i && cfg_all_bonded_i && cfg_refclk_par_i;

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        !q |=> bus_code_o == 2'b11);

    p_sync_first_r1: assert property (@(posedge clk) disable iff (rst)
        (q && ch_sync_i[mst_sel_i]) |=> bus_code_o == 2'b00);

    p_idle_code_r2: assert property (@(posedge clk) disable iff (rst)
        (q && !ch_sync_i[mst_sel_i] && !ch_frame_i[mst_sel_i]) |=> bus_code_o == 2'b11);

    p_sync_slot_r8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_master_i && bus_code_i == 2'b00) |=> !rd_vld_o);

    p_no_read_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> !rd_vld_o);
endmodule

bind bond_slip_link bond_slip_link_chk #(.NCH(NCH), .SELW(SELW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_master_i    (cfg_master_i),
    .cfg_all_bonded_i(cfg_all_bonded_i),
    .cfg_refclk_par_i(cfg_refclk_par_i),
    .mst_sel_i       (mst_sel_i),
    .ch_frame_i      (ch_frame_i),
    .ch_sync_i       (ch_sync_i),
    .bus_code_o      (bus_code_o),
    .bus_code_i      (bus_code_i),
    .rd_en_i         (rd_en_i),
    .rd_vld_o        (rd_vld_o)
);

// File: tb/bond_slip_link_tb.sv
`timescale 1ns/1ps
module bond_slip_link_tb;
    localparam int NCH = 4, DEPTH = 16, FW = 5, NCYC = 4000;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_m = 0, cfg_b = 0, cfg_r = 0;
    logic [1:0] sel = 0;
    logic [NCH*FW-1:0] fill = '0;
    logic [NCH-1:0] frame = '0, sync = '0;
    logic [1:0] code_o, bus_i = 2'b11;
    logic oe;
    logic wr_en = 0, wr_ctl = 0, rd_en = 0;
    logic [9:0] wr_sym = '0;
    logic rd_vld, rd_ctl;
    logic [9:0] rd_sym;

    always #2.5 clk = ~clk;

    bond_slip_link u_dut (
        .clk(clk), .rst(rst), .cfg_master_i(cfg_m), .cfg_all_bonded_i(cfg_b),
        .cfg_refclk_par_i(cfg_r), .mst_sel_i(sel), .ch_fill_i(fill),
        .ch_frame_i(frame), .ch_sync_i(sync), .bus_code_o(code_o), .bus_oe_o(oe),
        .bus_code_i(bus_i), .wr_en_i(wr_en), .wr_ctl_i(wr_ctl), .wr_sym_i(wr_sym),
        .rd_en_i(rd_en), .rd_vld_o(rd_vld), .rd_ctl_o(rd_ctl), .rd_sym_o(rd_sym)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    logic [10:0] m_mem [DEPTH];
    int m_wp = 0, m_rp = 0, m_pend = 0;   // 0 none, 1 add, 2 del
    bit m_ins = 0;
    bit e_vld = 0;
    logic [10:0] e_ent = '0;
    logic [1:0] e_code = 2'b11;
    string t_code = "R11", t_rd = "R11";

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_fr(logic [10:0] e);
        return e[10] && (e[9:0] == 10'h0FA || e[9:0] == 10'h305);
    endfunction

    function automatic logic [1:0] exp_code(bit q, logic [1:0] s, logic [NCH*FW-1:0] f,
                                            logic [NCH-1:0] fr, logic [NCH-1:0] sy);
        int lvl;
        if (!q) return 2'b11;
        lvl = int'(f[s*FW +: FW]);
        if (sy[s]) return 2'b00;
        if (fr[s] && lvl < DEPTH/4) return 2'b01;
        if (fr[s] && lvl > (3*DEPTH)/4) return 2'b10;
        return 2'b11;
    endfunction

    function automatic int mi(int p);
        return ((p % DEPTH) + DEPTH) % DEPTH;
    endfunction

    task automatic model_step();
        logic [1:0] cmd;
        int f;
        logic [10:0] hd;
        bit had_pend;
        cmd = cfg_m ? 2'b11 : bus_i;
        f = m_wp - m_rp;
        hd = m_mem[mi(m_rp)];
        had_pend = (m_pend != 0);
        e_vld = 0;
        t_rd = "R10";
        if (cfg_m && bus_i != 2'b11) t_rd = "R5";
        if (cmd == 2'b00) begin
            t_rd = "R8";
            m_rp = m_wp - DEPTH/2;
            m_pend = 0; m_ins = 0;
        end else begin
            if (rd_en) begin
                if (m_ins) begin
                    e_vld = 1; e_ent = {1'b1, 10'h0FA}; m_ins = 0; t_rd = "R6";
                end else if (f != 0) begin
                    m_rp++;
                    if (is_fr(hd) && m_pend == 2) begin
                        m_pend = 0; t_rd = "R7";
                    end else begin
                        e_vld = 1; e_ent = hd;
                        if (is_fr(hd) && m_pend == 1) begin
                            m_ins = 1; m_pend = 0; t_rd = "R6";
                        end
                    end
                end
            end
            if (cmd == 2'b01 || cmd == 2'b10) begin
                if (had_pend) t_rd = "R9";
                m_pend = (cmd == 2'b01) ? 1 : 2;
            end
        end
        if (wr_en && f < DEPTH) begin
            m_mem[mi(m_wp)] = {wr_ctl, wr_sym};
            m_wp++;
        end
    endtask

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(code_o == 2'b11, "R11", "bus_code_o", code_o, 2'b11);
        chk(rd_vld == 1'b0, "R11", "rd_vld_o", rd_vld, 0);
        chk(oe == 1'b0, "R11", "bus_oe_o", oe, 0);
        for (int c = 0; c < NCYC; c++) begin
            bit wbias;
            int r;
            // drive new inputs
            wbias = ((c / 150) % 2) == 0;
            r = $urandom_range(0, 99);
            cfg_m = (c < 300) ? (r < 80) : (r < 50);
            cfg_b = $urandom_range(0, 9) != 0;
            cfg_r = $urandom_range(0, 9) != 0;
            sel = 2'($urandom_range(0, 3));
            for (int k = 0; k < NCH; k++) fill[k*FW +: FW] = FW'($urandom_range(0, DEPTH));
            frame = NCH'($urandom);
            sync = '0;
            for (int k = 0; k < NCH; k++) sync[k] = ($urandom_range(0, 15) == 0);
            r = $urandom_range(0, 99);
            bus_i = (r < 10) ? 2'b01 : (r < 20) ? 2'b10 : (r < 23) ? 2'b00 : 2'b11;
            wr_en = $urandom_range(0, 99) < (wbias ? 85 : 35);
            rd_en = $urandom_range(0, 99) < (wbias ? 35 : 85);
            if ($urandom_range(0, 99) < 35) begin
                wr_ctl = 1'b1;
                wr_sym = $urandom_range(0, 1) ? 10'h0FA : 10'h305;
            end else begin
                wr_ctl = 1'($urandom);
                wr_sym = 10'($urandom);
            end
            e_code = exp_code(cfg_m && cfg_b && cfg_r, sel, fill, frame, sync);
            t_code = !(cfg_m && cfg_b && cfg_r) ? "R4" : sync[sel] ? "R1" :
                     frame[sel] ? "R2" : "R3";
            model_step();
            #1;
            chk(oe == (cfg_m && cfg_b && cfg_r), "R4", "bus_oe_o", oe, cfg_m && cfg_b && cfg_r);
            @(negedge clk);
            chk(code_o == e_code, t_code, "bus_code_o", code_o, e_code);
            if (e_vld)
                chk(rd_vld && {rd_ctl, rd_sym} == e_ent, t_rd, "read entry",
                    {rd_vld, rd_ctl, rd_sym}, {1'b1, e_ent});
            else
                chk(!rd_vld, t_rd, "rd_vld_o", rd_vld, 0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule